// File: doc/BRIEF.md
# Slot-Demultiplexed Fragment Builder

This block receives a serial stream of fixed 35-bit frames from a link multiplexer. It checks each frame and sorts the payload words into per-channel fragments in a shared memory. Words carry no channel number. A frame whose 32 data bits are all zero marks the start of a cycle. The 18 frames that follow it are the slots of channels 0 through 17, in that order. A word's channel is known only from its slot position after the marker.

Marker words and empty slot words (all zero) are checked but never stored. Each non-empty slot word is appended to its channel's 64-word partition, so each fragment keeps its words in arrival order. Later logic reads a fragment through a combinational read port, which takes a channel and an index and returns the stored word and the channel's word count. It then releases the partition with a per-channel clear pulse.

The serial input is a valid-qualified bit stream with no back-pressure. The block takes one bit in every cycle where `ser_valid` is high and never stalls the sender. Cycles with `ser_valid` low are ignored and may fall anywhere, including inside a frame.

Top module: `slot_frag_builder`

## Requirements
- R1: A frame starts with a 1 bit while idle. It carries 32 data bits with the most significant bit first, then a parity bit chosen so that the data and parity bits together hold an odd number of ones, then a stop bit that must be 0. 0 bits while idle and cycles with `ser_valid` low are ignored.
- R2: A frame with wrong parity or a stop bit of 1 sets `frame_err`, which stays set until reset. That word is never stored. While locked it still occupies its slot, so the next slot maps to the next channel.
- R3: After reset `sync` is 0, and nonzero words are not stored. The first error-free all-zero word sets `sync` to 1.
- R4: While locked, the k-th frame after a marker (k = 1..18) belongs to channel k-1. The frame after the 18th slot is expected to be the next marker.
- R5: Marker words and all-zero slot words are never stored and leave the word counts unchanged.
- R6: When the frame in a marker position is nonzero or faulty, `sync` drops to 0. Later words are not stored until a new all-zero word is seen.
- R7: Stored word i of a channel (i from 0) is read back at index i. `rd_count` gives the number of stored words.
- R8: A partition holds at most 64 words. A word for a full channel is dropped, that channel's `ovf` bit is set, and the count stays at 64.
- R9: A one-cycle pulse on `clr[c]` sets channel c's count to 0 and clears `ovf[c]`. The next stored word goes to index 0. A clear wins over a write to the same channel in the same cycle.
- R10: The read port is combinational. A channel number of 18 or more returns data 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_valid | input | 1 | Qualifies `ser_bit` in this cycle |
| ser_bit | input | 1 | Serial frame bit |
| clr | input | 18 | Per-channel partition clear pulse |
| rd_chan | input | 5 | Channel to read |
| rd_idx | input | 6 | Word index within the partition |
| rd_data | output | 32 | Stored word at (`rd_chan`, `rd_idx`) |
| rd_count | output | 7 | Words stored for `rd_chan` |
| ovf | output | 18 | Per-channel partition-full drop flag |
| sync | output | 1 | Locked to the slot cycle |
| frame_err | output | 1 | Sticky parity or stop-bit error |

## Verification
The stream is driven in several patterns. Alternating empty and full slots show that channel mapping comes from position alone. Slot words with the top bit set and gaps inside frames expose bit-order and valid-handling faults. Frames with a bad stop bit or bad parity, placed in slot positions, show that faulty words are dropped while the slot still advances. A nonzero word in a marker position, followed by nonzero words, tells apart losing sync from simply skipping one cycle. Filling a single channel past 64 words and then clearing it checks the boundary at the partition limit and the restart at index 0.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
package sfb_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CHANNELS   = 18;
  localparam int unsigned PART_WORDS = 64;

  typedef enum logic {
    LINK_HUNT,
    LINK_LOCKED
  } link_state_t;
endpackage

// File: rtl/sfb_deser.sv
`timescale 1ns/1ps
// Serial-to-word converter: start, MSB-first data, odd parity, stop.
module sfb_deser #(
  parameter int unsigned DW = sfb_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_in,
  output logic          word_vld,
  output logic [DW-1:0] word_data,
  output logic          word_bad
);
  localparam int unsigned FLEN = DW + 3;
  localparam int unsigned PW   = $clog2(FLEN);

  logic [PW-1:0] pos;
  logic [DW-1:0] shreg;
  logic          par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      shreg     <= '0;
      par       <= 1'b0;
      word_vld  <= 1'b0;
      word_data <= '0;
      word_bad  <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (bit_vld) begin
        if (pos == '0) begin
          if (bit_in) pos <= PW'(1);
        end else if (pos <= PW'(DW)) begin
          shreg <= {shreg[DW-2:0], bit_in};
          pos   <= pos + PW'(1);
        end else if (pos == PW'(DW + 1)) begin
          par <= bit_in;
          pos <= pos + PW'(1);
        end else begin
          word_vld  <= 1'b1;
          word_data <= shreg;
          word_bad  <= !(^{shreg, par}) || bit_in;
          pos       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sfb_slot.sv
`timescale 1ns/1ps
// Slot tracker: locks on an all-zero word and maps slot position to channel.
module sfb_slot #(
  parameter int unsigned NCH = sfb_pkg::CHANNELS,
  parameter int unsigned DW  = sfb_pkg::DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   word_vld,
  input  logic [DW-1:0]          word_data,
  input  logic                   word_bad,
  output logic                   wr_en,
  output logic [$clog2(NCH)-1:0] wr_chan,
  output logic [DW-1:0]          wr_data,
  output logic                   locked,
  output logic                   err_seen
);
  import sfb_pkg::*;
  localparam int unsigned CHW = $clog2(NCH);
  localparam int unsigned SW  = $clog2(NCH + 1);

  link_state_t   state;
  logic [SW-1:0] slot;   // 0 = marker expected, k = channel k-1
  logic          is_zero;

  assign is_zero = (word_data == '0);
  assign locked  = (state == LINK_LOCKED);

  always_comb begin
    wr_en   = word_vld && locked && (slot != '0) && !word_bad && !is_zero;
    wr_chan = CHW'(slot - SW'(1));
    wr_data = word_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LINK_HUNT;
      slot     <= '0;
      err_seen <= 1'b0;
    end else begin
      if (word_vld && word_bad) err_seen <= 1'b1;
      if (word_vld) begin
        if (state == LINK_HUNT) begin
          if (!word_bad && is_zero) begin
            state <= LINK_LOCKED;
            slot  <= SW'(1);
          end
        end else if (slot == '0) begin
          if (word_bad || !is_zero) state <= LINK_HUNT;
          else                      slot  <= SW'(1);
        end else begin
          slot <= (slot == SW'(NCH)) ? '0 : slot + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sfb_store.sv
`timescale 1ns/1ps
// Partitioned word store with per-channel fill counters.
module sfb_store #(
  parameter int unsigned NCH = sfb_pkg::CHANNELS,
  parameter int unsigned PW  = sfb_pkg::PART_WORDS,
  parameter int unsigned DW  = sfb_pkg::DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_chan,
  input  logic [DW-1:0]          wr_data,
  input  logic [NCH-1:0]         clr,
  input  logic [$clog2(NCH)-1:0] rd_chan,
  input  logic [$clog2(PW)-1:0]  rd_idx,
  output logic [DW-1:0]          rd_data,
  output logic [$clog2(PW):0]    rd_count,
  output logic [NCH-1:0]         ovf
);
  localparam int unsigned CHW   = $clog2(NCH);
  localparam int unsigned IW    = $clog2(PW);
  localparam int unsigned NW    = IW + 1;
  localparam int unsigned DEPTH = NCH * PW;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [NW-1:0] cnt [NCH];
  logic [AW-1:0] wa, ra;
  logic          wr_full;

  always_comb begin
    wr_full = (cnt[wr_chan] == NW'(PW));
    wa = AW'(wr_chan) * AW'(PW) + AW'(cnt[wr_chan][IW-1:0]);
    ra = AW'(rd_chan) * AW'(PW) + AW'(rd_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < int'(NCH); c++) cnt[c] <= '0;
      ovf <= '0;
    end else begin
      for (int c = 0; c < int'(NCH); c++) begin
        if (clr[c]) begin
          cnt[c] <= '0;
          ovf[c] <= 1'b0;
        end else if (wr_en && wr_chan == CHW'(c)) begin
          if (cnt[c] == NW'(PW)) ovf[c] <= 1'b1;
          else                   cnt[c] <= cnt[c] + NW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr[wr_chan] && !wr_full) mem[wa] <= wr_data;
  end

  always_comb begin
    if (rd_chan < CHW'(NCH)) begin
      rd_data  = mem[ra];
      rd_count = cnt[rd_chan];
    end else begin
      rd_data  = '0;
      rd_count = '0;
    end
  end
endmodule

// File: rtl/slot_frag_builder.sv
`timescale 1ns/1ps
module slot_frag_builder #(
  parameter int unsigned NCH = sfb_pkg::CHANNELS,
  parameter int unsigned PW  = sfb_pkg::PART_WORDS,
  parameter int unsigned DW  = sfb_pkg::DATA_W,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned IW  = $clog2(PW),
  localparam int unsigned NW  = IW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_valid,
  input  logic           ser_bit,
  input  logic [NCH-1:0] clr,
  input  logic [CHW-1:0] rd_chan,
  input  logic [IW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic [NW-1:0]  rd_count,
  output logic [NCH-1:0] ovf,
  output logic           sync,
  output logic           frame_err
);
  logic           w_vld, w_bad;
  logic [DW-1:0]  w_data;
  logic           wr_en;
  logic [CHW-1:0] wr_chan;
  logic [DW-1:0]  wr_data;

  sfb_deser #(.DW(DW)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_vld(ser_valid), .bit_in(ser_bit),
    .word_vld(w_vld), .word_data(w_data), .word_bad(w_bad)
  );

  sfb_slot #(.NCH(NCH), .DW(DW)) u_slot (
    .clk(clk), .rst_n(rst_n), .word_vld(w_vld), .word_data(w_data),
    .word_bad(w_bad), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
    .locked(sync), .err_seen(frame_err)
  );

  sfb_store #(.NCH(NCH), .PW(PW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_data(wr_data), .clr(clr), .rd_chan(rd_chan), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_count(rd_count), .ovf(ovf)
  );
endmodule

// File: rtl/sfb_chk.sv
`timescale 1ns/1ps
module sfb_chk #(
  parameter int unsigned NCH = 18,
  parameter int unsigned PW  = 64,
  parameter int unsigned DW  = 32,
  parameter int unsigned CHW = 5,
  parameter int unsigned NW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_err,
  input logic [NCH-1:0] ovf,
  input logic [NCH-1:0] clr,
  input logic [CHW-1:0] rd_chan,
  input logic [NW-1:0]  rd_count,
  input logic           wr_en,
  input logic [DW-1:0]  wr_data
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R2

  AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data != '0)); // R5

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= NW'(PW)); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ovf) & ~$past(clr)) & ~ovf) == '0)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chan == $past(rd_chan)) |->
      (({1'b0, rd_count} <= {1'b0, $past(rd_count)} + 1'b1) || rd_count == '0)); // R7
endmodule

bind slot_frag_builder sfb_chk #(
  .NCH(NCH), .PW(PW), .DW(DW), .CHW(CHW), .NW(NW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_err(frame_err), .ovf(ovf), .clr(clr),
  .rd_chan(rd_chan), .rd_count(rd_count), .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/sim_slot_frag_builder.sv
`timescale 1ns/1ps
module sim_slot_frag_builder;
  localparam int NCH = 18;
  localparam int PW  = 64;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ser_valid, ser_bit;
  logic [NCH-1:0] clr;
  logic [4:0]     rd_chan;
  logic [5:0]     rd_idx;
  logic [31:0]    rd_data;
  logic [6:0]     rd_count;
  logic [NCH-1:0] ovf;
  logic           sync, frame_err;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [31:0] expq [NCH][$];
  logic [31:0] cyc [NCH];
  logic [NCH-1:0] bp, bs;

  always #2.5 clk = ~clk;

  slot_frag_builder u0 (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_bit(ser_bit),
    .clr(clr), .rd_chan(rd_chan), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_count(rd_count), .ovf(ovf), .sync(sync), .frame_err(frame_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_valid = 1'b1;
    ser_bit   = b;
  endtask

  task automatic send_frame(input logic [31:0] d, input bit bad_par, input bit bad_stop, input bit gap);
    send_bit(1'b1);
    for (int i = 31; i >= 0; i--) begin
      send_bit(d[i]);
      if (gap && i == 20) begin
        @(negedge clk);
        ser_valid = 1'b0;
        ser_bit   = 1'b1;
      end
    end
    send_bit((~^d) ^ bad_par);
    send_bit(bad_stop);
    @(negedge clk);
    ser_valid = 1'b0;
    ser_bit   = 1'b0;
  endtask

  task automatic settle();
    ser_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Driver: marker plus 18 slots; good nonzero words become expected items.
  task automatic put_cycle();
    send_frame(32'h0, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < NCH; c++) begin
      send_frame(cyc[c], bp[c], bs[c], (c % 5) == 0);
      if (!bp[c] && !bs[c] && cyc[c] != 0 && expq[c].size() < PW)
        expq[c].push_back(cyc[c]);
    end
    settle();
  endtask

  task automatic clear_cycle();
    for (int c = 0; c < NCH; c++) cyc[c] = 32'h0;
    bp = '0;
    bs = '0;
  endtask

  // Monitor: pops expected items in order and compares with the read port.
  task automatic check_chan(input int c, input string req);
    logic [31:0] q [$];
    q = expq[c];
    rd_chan = 5'(c);
    #0.5;
    check({req, " count"}, 64'(rd_count), 64'(q.size()));
    for (int i = 0; q.size() > 0; i++) begin
      logic [31:0] e;
      e = q.pop_front();
      rd_idx = 6'(i);
      #0.5;
      check({req, " data"}, 64'(rd_data), 64'(e));
    end
  endtask

  task automatic pulse_clr(input int c);
    @(negedge clk);
    clr[c] = 1'b1;
    @(negedge clk);
    clr = '0;
    expq[c].delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ser_valid = 1'b0; ser_bit = 1'b0; clr = '0;
    rd_chan = '0; rd_idx = '0;
    clear_cycle();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R3 reset sync", 64'(sync), 64'(0));
    check("R2 reset frame_err", 64'(frame_err), 64'(0));
    check("R8 reset ovf", 64'(ovf), 64'(0));
    check_chan(0, "R7 reset");

    // R3: nonzero words before any marker are not stored
    send_frame(32'hDEAD_0001, 0, 0, 0);
    send_frame(32'h8000_0002, 0, 0, 1);
    send_frame(32'h0000_0103, 0, 0, 0);
    settle();
    check("R3 unsynced", 64'(sync), 64'(0));
    check_chan(0, "R3 unsynced store");

    // R4 R5: even channels carry words, odd slots empty
    for (int c = 0; c < NCH; c++)
      cyc[c] = (c % 2 == 0) ? (32'hA000_0005 | (32'(c) << 8)) : 32'h0;
    put_cycle();
    check("R3 locked", 64'(sync), 64'(1));
    // R1: MSB set patterns, all slots full
    for (int c = 0; c < NCH; c++) cyc[c] = 32'h8000_0001 + 32'(c) * 32'h0101_0000;
    put_cycle();
    for (int c = 0; c < NCH; c++) check_chan(c, "R1 R4 R5 R7");

    // R2: bad stop bit in slot 0
    clear_cycle();
    bs[0] = 1'b1;
    cyc[0] = 32'h1111_0000;
    put_cycle();
    check("R2 stop error", 64'(frame_err), 64'(1));
    // R2: bad parity in slot 0, slot still advances to channel 1
    clear_cycle();
    bp[0] = 1'b1;
    cyc[0] = 32'h2222_0000;
    cyc[1] = 32'h1234_5678;
    put_cycle();
    check_chan(0, "R2 parity drop");
    check_chan(1, "R2 slot advance");
    check("R2 sync kept", 64'(sync), 64'(1));

    // R6: nonzero word in marker position
    send_frame(32'h0000_0F00, 0, 0, 0);
    settle();
    check("R6 sync lost", 64'(sync), 64'(0));
    send_frame(32'h7700_0001, 0, 0, 0);
    send_frame(32'h7700_0002, 0, 0, 0);
    send_frame(32'h7700_0003, 0, 0, 0);
    settle();
    check_chan(0, "R6 no store");
    check_chan(1, "R6 no store");
    check_chan(2, "R6 no store");

    // R9: clear channel 5
    pulse_clr(5);
    check_chan(5, "R9 clear");

    // R8: fill channel 5 past its partition
    clear_cycle();
    for (int k = 0; k < PW + 2; k++) begin
      cyc[5] = 32'h5500_0000 + 32'(k);
      put_cycle();
    end
    check("R8 ovf bit", 64'(ovf), 64'(1) << 5);
    check_chan(5, "R8 full");

    // R9: clear releases overflow and restarts at index 0
    pulse_clr(5);
    check("R9 ovf cleared", 64'(ovf), 64'(0));
    clear_cycle();
    cyc[5] = 32'hC1EA_0001;
    put_cycle();
    check_chan(5, "R9 restart");

    // R10: out-of-range channel
    rd_chan = 5'd20;
    rd_idx  = 6'd0;
    #0.5;
    check("R10 data", 64'(rd_data), 64'(0));
    check("R10 count", 64'(rd_count), 64'(0));

    finish_run();
  end
endmodule